// File: doc/BRIEF.md
# Output Termination Fault Monitor with Peak Capture

This block watches the termination state of a two-leg output stage, one true leg and one complement leg. An amplitude sensor outside the block delivers a 5-bit count for each leg, each with its own valid strobe. An unterminated output shows a larger swing than expected. The block compares each valid count with a 4-bit threshold and raises a per-leg fault flag when the count is too high. The threshold comes from one of two settings, picked by the rate select: one setting for standard-definition edge rates and one for high-definition edge rates. Each setting is split into an upper field and a separate low bit. Typical settings are 9 for HD and 5 for SD.

Detection runs only while the output driver is enabled, and only after the driver has been on for a settle period. That period is a parameter in clock cycles and is about 4 ms in a real system. When the driver is disabled, both flags clear and the settle period starts again.

A peak-capture engine helps software calibrate the thresholds. A 3-bit command, issued with a strobe, does one of four things: clears the stored extreme to 0 and tracks maxima, presets it to 31 and tracks minima, or selects which leg is captured. Each leg has a registered readback port. It returns either the most recent valid count of that leg or, for the leg under capture, the stored extreme.

Top module: `term_fault_monitor`

## Requirements
- R1: After reset both fault flags are 0, both readbacks are 0, no leg is under capture, the stored extreme is 0 and tracking is maximum.
- R2: The active threshold is {hd_thr_hi, hd_thr_lsb} when rate_sd is 0 (HD) and {sd_thr_hi, sd_thr_lsb} when rate_sd is 1 (SD), with the upper field in the three most significant bits.
- R3: While detection is armed, a valid sample of a leg sets that leg's flag on the next clock if the count is strictly greater than the active threshold, and clears it if the count is at or below the threshold. Without a valid sample the flag holds.
- R4: Detection is armed only once drv_enable has been high for SETTLE_CYC consecutive clocks. Valid samples that arrive before that leave the flags at 0.
- R5: A clock with drv_enable low clears both flags on that clock and restarts the settle count.
- R6: Command 000 sets the stored extreme to 0, sets tracking to maximum and returns both readbacks to live counts.
- R7: Command 001 puts the true leg under capture and command 010 puts the complement leg under capture. The captured leg's readback shows the stored extreme and the other leg's readback shows its latest valid count. Each readback reflects the block state one clock after that state is updated.
- R8: Command 101 sets the stored extreme to 31 and tracking to minimum, and leaves the capture selection unchanged.
- R9: Commands 011, 100, 110 and 111 change no state.
- R10: The stored extreme takes a new value only on a valid sample of the captured leg that is strictly greater (maximum tracking) or strictly smaller (minimum tracking) than the stored value. On a clock where a command is issued, the command takes effect and no peak update happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_enable | input | 1 | Output driver powered on |
| rate_sd | input | 1 | Effective rate select, 1 = SD, 0 = HD |
| hd_thr_hi | input | TW-1 | Upper threshold bits for HD rate |
| hd_thr_lsb | input | 1 | Threshold low bit for HD rate |
| sd_thr_hi | input | TW-1 | Upper threshold bits for SD rate |
| sd_thr_lsb | input | 1 | Threshold low bit for SD rate |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Compare/capture command code |
| cnt_true | input | CW | Amplitude count, true leg |
| cnt_true_vld | input | 1 | Valid strobe for cnt_true |
| cnt_comp | input | CW | Amplitude count, complement leg |
| cnt_comp_vld | input | 1 | Valid strobe for cnt_comp |
| fault_true | output | 1 | Termination fault, true leg |
| fault_comp | output | 1 | Termination fault, complement leg |
| rdbk_true | output | CW | Readback, true leg |
| rdbk_comp | output | CW | Readback, complement leg |

## Verification
Directed steps put counts exactly at the threshold and one above it, in both rate modes and with different threshold fields. This separates a strict compare from an inclusive one, and shows whether the correct threshold setting is used. Other directed steps send valid samples just before and just after the settle period ends, and toggle the enable line, to locate the arming boundary. A capture sequence under both maximum and minimum tracking mixes better, equal and worse samples on both legs, including samples that arrive on a command clock. It confirms that only strict improvements on the selected leg are stored and that reserved codes change nothing. A long random phase then mixes every command code, sparse strobes, rate changes and enable drops, and checks every clock against the bench model.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  localparam logic [2:0] CMD_CLR_MAX  = 3'b000;
  localparam logic [2:0] CMD_CAP_TRUE = 3'b001;
  localparam logic [2:0] CMD_CAP_COMP = 3'b010;
  localparam logic [2:0] CMD_SET_MIN  = 3'b101;
endpackage

// File: rtl/tfm_settle.sv
module tfm_settle #(
  parameter int SETTLE_CYC = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic armed
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] LIMIT = SW'(SETTLE_CYC);

  logic [SW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q <= '0;
    end else if (run_q != LIMIT) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign armed = (run_q == LIMIT);
endmodule

// File: rtl/tfm_leg_detect.sv
module tfm_leg_detect #(
  parameter int CW = 5,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          armed,
  input  logic          vld,
  input  logic [CW-1:0] cnt,
  input  logic [TW-1:0] thr,
  output logic          fault
);
  logic fault_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      fault_q <= 1'b0;
    end else if (armed && vld) begin
      fault_q <= (cnt > CW'(thr));
    end
  end

  assign fault = fault_q;
endmodule

// File: rtl/tfm_peak_engine.sv
module tfm_peak_engine #(
  parameter int CW   = 5,
  parameter int NLEG = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd,
  input  logic [NLEG-1:0]           vld,
  input  logic [NLEG-1:0][CW-1:0]   cnt,
  output logic [NLEG-1:0]           cap_mask,
  output logic [CW-1:0]             peak
);
  import tfm_pkg::*;
  localparam int LW = (NLEG > 1) ? $clog2(NLEG) : 1;

  logic          cap_on_q;
  logic [LW-1:0] cap_leg_q;
  logic          trk_min_q;
  logic [CW-1:0] peak_q;
  logic [CW-1:0] cand;
  logic          take;

  always_comb begin
    cand = cnt[cap_leg_q];
    take = cap_on_q && vld[cap_leg_q] &&
           (trk_min_q ? (cand < peak_q) : (cand > peak_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_on_q  <= 1'b0;
      cap_leg_q <= '0;
      trk_min_q <= 1'b0;
      peak_q    <= '0;
    end else if (cmd_valid) begin
      case (cmd)
        CMD_CLR_MAX: begin
          peak_q    <= '0;
          trk_min_q <= 1'b0;
          cap_on_q  <= 1'b0;
        end
        CMD_CAP_TRUE: begin
          cap_on_q  <= 1'b1;
          cap_leg_q <= LW'(0);
        end
        CMD_CAP_COMP: begin
          cap_on_q  <= 1'b1;
          cap_leg_q <= LW'(1);
        end
        CMD_SET_MIN: begin
          peak_q    <= '1;
          trk_min_q <= 1'b1;
        end
        default: ;
      endcase
    end else if (take) begin
      peak_q <= cand;
    end
  end

  assign cap_mask = cap_on_q ? (NLEG'(1) << cap_leg_q) : '0;
  assign peak     = peak_q;
endmodule

// File: rtl/term_fault_monitor.sv
module term_fault_monitor #(
  parameter int CW         = 5,
  parameter int TW         = 4,
  parameter int SETTLE_CYC = 200000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drv_enable,
  input  logic          rate_sd,
  input  logic [TW-2:0] hd_thr_hi,
  input  logic          hd_thr_lsb,
  input  logic [TW-2:0] sd_thr_hi,
  input  logic          sd_thr_lsb,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [CW-1:0] cnt_true,
  input  logic          cnt_true_vld,
  input  logic [CW-1:0] cnt_comp,
  input  logic          cnt_comp_vld,
  output logic          fault_true,
  output logic          fault_comp,
  output logic [CW-1:0] rdbk_true,
  output logic [CW-1:0] rdbk_comp
);
  localparam int NLEG = 2;

  logic [NLEG-1:0]         vld_a;
  logic [NLEG-1:0][CW-1:0] cnt_a;
  logic [NLEG-1:0]         fault_a;
  logic [NLEG-1:0]         cap_mask;
  logic [NLEG-1:0][CW-1:0] rb_q;
  logic [CW-1:0]           peak;
  logic [TW-1:0]           thr;
  logic                    armed;

  assign vld_a = {cnt_comp_vld, cnt_true_vld};
  assign cnt_a = {cnt_comp, cnt_true};
  assign thr   = rate_sd ? {sd_thr_hi, sd_thr_lsb} : {hd_thr_hi, hd_thr_lsb};

  tfm_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .en(drv_enable), .armed(armed)
  );

  tfm_peak_engine #(.CW(CW), .NLEG(NLEG)) u_peak (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
    .vld(vld_a), .cnt(cnt_a), .cap_mask(cap_mask), .peak(peak)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic [CW-1:0] live_q;

    tfm_leg_detect #(.CW(CW), .TW(TW)) u_det (
      .clk(clk), .rst(rst), .en(drv_enable), .armed(armed),
      .vld(vld_a[g]), .cnt(cnt_a[g]), .thr(thr), .fault(fault_a[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        live_q  <= '0;
        rb_q[g] <= '0;
      end else begin
        if (vld_a[g]) live_q <= cnt_a[g];
        rb_q[g] <= cap_mask[g] ? peak : live_q;
      end
    end
  end

  assign fault_true = fault_a[0];
  assign fault_comp = fault_a[1];
  assign rdbk_true  = rb_q[0];
  assign rdbk_comp  = rb_q[1];
endmodule

// File: rtl/tfm_checker.sv
module tfm_checker #(
  parameter int CW         = 5,
  parameter int TW         = 4,
  parameter int SETTLE_CYC = 200000
) (
  input logic          clk,
  input logic          rst,
  input logic          drv_enable,
  input logic          rate_sd,
  input logic [TW-2:0] hd_thr_hi,
  input logic          hd_thr_lsb,
  input logic [TW-2:0] sd_thr_hi,
  input logic          sd_thr_lsb,
  input logic [CW-1:0] cnt_true,
  input logic          cnt_true_vld,
  input logic [CW-1:0] cnt_comp,
  input logic          cnt_comp_vld,
  input logic          fault_true,
  input logic          fault_comp
);
  int unsigned en_run;
  logic [TW-1:0] thr_c;
  logic          live;

  always_ff @(posedge clk) begin
    if (rst || !drv_enable) en_run <= 0;
    else if (en_run < SETTLE_CYC) en_run <= en_run + 1;
  end

  assign thr_c = rate_sd ? {sd_thr_hi, sd_thr_lsb} : {hd_thr_hi, hd_thr_lsb};
  assign live  = drv_enable && (en_run == SETTLE_CYC);

  // R5
  a_r5_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !drv_enable |=> (!fault_true && !fault_comp));

  // R4
  a_r4_quiet_before_settle: assert property (@(posedge clk) disable iff (rst)
    (en_run < SETTLE_CYC) |-> (!fault_true && !fault_comp));

  // R3
  a_r3_hold_true: assert property (@(posedge clk) disable iff (rst)
    (drv_enable && !cnt_true_vld) |=> $stable(fault_true));

  a_r3_hold_comp: assert property (@(posedge clk) disable iff (rst)
    (drv_enable && !cnt_comp_vld) |=> $stable(fault_comp));

  // R2, R3
  a_r3_set_true: assert property (@(posedge clk) disable iff (rst)
    (live && cnt_true_vld && (cnt_true > CW'(thr_c))) |=> fault_true);

  a_r3_clear_true: assert property (@(posedge clk) disable iff (rst)
    (live && cnt_true_vld && (cnt_true <= CW'(thr_c))) |=> !fault_true);

  a_r2_set_comp: assert property (@(posedge clk) disable iff (rst)
    (live && cnt_comp_vld && (cnt_comp > CW'(thr_c))) |=> fault_comp);

  a_r2_clear_comp: assert property (@(posedge clk) disable iff (rst)
    (live && cnt_comp_vld && (cnt_comp <= CW'(thr_c))) |=> !fault_comp);
endmodule

bind term_fault_monitor tfm_checker #(.CW(CW), .TW(TW), .SETTLE_CYC(SETTLE_CYC)) u_chk (.*);

// File: tb/term_fault_monitor_tb.sv
module term_fault_monitor_tb;
  localparam int CW = 5;
  localparam int TW = 4;
  localparam int S  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, rsd = 1'b0;
  logic [2:0] hh = 3'b100, sh = 3'b010;
  logic hl = 1'b1, sl = 1'b1;
  logic cv = 1'b0;
  logic [2:0] cm = 3'b000;
  logic [CW-1:0] cp = '0, cn = '0;
  logic vp = 1'b0, vn = 1'b0;
  logic fp, fn;
  logic [CW-1:0] rbp, rbn;

  int nchk = 0, nerr = 0;
  bit done = 0;

  int m_set, m_sel, m_peak;
  bit m_fp, m_fn, m_min;
  int m_live0, m_live1, m_rb0, m_rb1;

  always #10 clk = ~clk;

  term_fault_monitor #(.CW(CW), .TW(TW), .SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst(rst), .drv_enable(en), .rate_sd(rsd),
    .hd_thr_hi(hh), .hd_thr_lsb(hl), .sd_thr_hi(sh), .sd_thr_lsb(sl),
    .cmd_valid(cv), .cmd(cm),
    .cnt_true(cp), .cnt_true_vld(vp), .cnt_comp(cn), .cnt_comp_vld(vn),
    .fault_true(fp), .fault_comp(fn), .rdbk_true(rbp), .rdbk_comp(rbn)
  );

  function automatic int thr_f();
    return rsd ? int'({sh, sl}) : int'({hh, hl});
  endfunction

  function automatic bit better(int c);
    return m_min ? (c < m_peak) : (c > m_peak);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_set = 0; m_sel = 0; m_peak = 0; m_fp = 0; m_fn = 0; m_min = 0;
    m_live0 = 0; m_live1 = 0; m_rb0 = 0; m_rb1 = 0;
  endtask

  task automatic model_step();
    bit armed;
    int thr;
    armed = (m_set == S);
    thr = thr_f();
    m_rb0 = (m_sel == 1) ? m_peak : m_live0;
    m_rb1 = (m_sel == 2) ? m_peak : m_live1;
    if (!en) begin
      m_fp = 0; m_fn = 0; m_set = 0;
    end else begin
      if (armed && vp) m_fp = (int'(cp) > thr);
      if (armed && vn) m_fn = (int'(cn) > thr);
      if (m_set < S) m_set++;
    end
    if (cv) begin
      case (cm)
        3'b000: begin m_peak = 0; m_min = 0; m_sel = 0; end
        3'b001: m_sel = 1;
        3'b010: m_sel = 2;
        3'b101: begin m_peak = 31; m_min = 1; end
        default: ;
      endcase
    end else if (m_sel == 1 && vp && better(int'(cp))) m_peak = int'(cp);
    else if (m_sel == 2 && vn && better(int'(cn))) m_peak = int'(cn);
    if (vp) m_live0 = int'(cp);
    if (vn) m_live1 = int'(cn);
  endtask

  task automatic cyc(string tf, string tr);
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    chk(tf, "fault_true", int'(fp), int'(m_fp));
    chk(tf, "fault_comp", int'(fn), int'(m_fn));
    chk(tr, "rdbk_true", int'(rbp), m_rb0);
    chk(tr, "rdbk_comp", int'(rbn), m_rb1);
    cv = 1'b0; vp = 1'b0; vn = 1'b0;
  endtask

  task automatic idle(int n, string tf, string tr);
    for (int i = 0; i < n; i++) cyc(tf, tr);
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    @(negedge clk);
    idle(3, "R1", "R1");
    rst = 1'b0;
    cyc("R1", "R1");
    // R4: enable, samples before settle must be ignored
    en = 1'b1;
    for (int i = 0; i < S - 1; i++) begin
      cp = 5'd31; vp = 1'b1; cn = 5'd30; vn = 1'b1;
      cyc("R4", "R7");
    end
    cyc("R4", "R7");
    // R3: HD threshold 9, boundary
    cp = 5'd9; vp = 1'b1; cn = 5'd10; vn = 1'b1; cyc("R3", "R7");
    cyc("R3", "R7");
    cp = 5'd10; vp = 1'b1; cn = 5'd9; vn = 1'b1; cyc("R3", "R7");
    // R2: SD threshold 5, and changed HD field
    rsd = 1'b1;
    cp = 5'd5; vp = 1'b1; cn = 5'd6; vn = 1'b1; cyc("R2", "R7");
    cp = 5'd6; vp = 1'b1; cyc("R2", "R7");
    rsd = 1'b0; hh = 3'b001; hl = 1'b0;
    cp = 5'd3; vp = 1'b1; cn = 5'd2; vn = 1'b1; cyc("R2", "R7");
    hh = 3'b100; hl = 1'b1;
    // R5: disable clears and restarts settle
    en = 1'b0; cyc("R5", "R7");
    en = 1'b1;
    cp = 5'd20; vp = 1'b1; cyc("R5", "R7");
    idle(S, "R4", "R7");
    cp = 5'd20; vp = 1'b1; cyc("R4", "R7");
    // R6/R7/R10: max capture on true leg
    cv = 1'b1; cm = 3'b000; cyc("R6", "R6");
    cv = 1'b1; cm = 3'b001; cyc("R7", "R7");
    cp = 5'd7; vp = 1'b1; cn = 5'd29; vn = 1'b1; cyc("R10", "R10");
    cp = 5'd4; vp = 1'b1; cyc("R10", "R10");
    cp = 5'd12; vp = 1'b1; cyc("R10", "R10");
    cv = 1'b1; cm = 3'b011; cp = 5'd25; vp = 1'b1; cyc("R9", "R10");
    idle(2, "R9", "R9");
    for (int c = 0; c < 8; c++) begin
      if (c == 3'b011 || c == 3'b100 || c == 3'b110 || c == 3'b111) begin
        cv = 1'b1; cm = 3'(c); cyc("R9", "R9");
      end
    end
    idle(2, "R9", "R9");
    // R8: minimum tracking on complement leg
    cv = 1'b1; cm = 3'b010; cyc("R7", "R7");
    cv = 1'b1; cm = 3'b101; cyc("R8", "R8");
    idle(2, "R8", "R8");
    cn = 5'd20; vn = 1'b1; cp = 5'd1; vp = 1'b1; cyc("R10", "R10");
    cn = 5'd22; vn = 1'b1; cyc("R10", "R10");
    cn = 5'd20; vn = 1'b1; cyc("R10", "R10");
    cn = 5'd9; vn = 1'b1; cyc("R10", "R10");
    idle(2, "R10", "R10");
    cv = 1'b1; cm = 3'b000; cyc("R6", "R6");
    idle(2, "R6", "R6");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 150 == 0) en = ~en;
      if ($urandom % 100 == 0) rsd = ~rsd;
      cp = 5'($urandom); vp = 1'($urandom);
      cn = 5'($urandom); vn = 1'($urandom);
      if ($urandom % 12 == 0) begin cv = 1'b1; cm = 3'($urandom); end
      cyc("R3", "R7");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog run did not finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule